// File: doc/BRIEF.md
# Memory protection control and region resolver

This block keeps the control word and the region selector of an eight-region memory protection unit, and decides for every memory access which region governs it, or whether the access faults. Software reaches the two registers over a small register bus. Each bus request carries a privilege flag, and only privileged requests may touch the registers. The bus also carries a write to the base-address slot. When that write has its valid flag set, it updates the selector as a side effect. The base-address storage itself lives outside this block.

The access-check side has no clock. Address decoders elsewhere supply one hit bit per region. The region descriptors supply one enable bit per region. With these, the block receives the privilege of the access and whether it comes from a high-priority fault handler. It returns the index of the governing region, a flag for the privileged fallback map, a flag for unprotected pass-through, and a fault flag. A separate output flags the one control setting whose outcome is undefined.

Top module: `mpu_guard_top`

## Requirements
- R1: After reset, both the control register (offset 0x0) and the selector register (offset 0x4) read as zero.
- R2: A privileged write to offset 0x0 stores wdata bits 2:0 as enable (bit 0), fault-handler protection (bit 1) and fallback map (bit 2). The new value governs the access check from the next clock edge. Bits 31:3 read as zero.
- R3: A privileged write to offset 0x4 stores only wdata bits 2:0, so a write of 13 reads back as 5. Reads return the value zero-extended to 32 bits.
- R4: A privileged write to offset 0x8 with wdata bit 4 set loads wdata bits 2:0 into the selector. With bit 4 clear, the selector is unchanged. A read of offset 0x8 returns zero.
- R5: An unprivileged read or write to any offset changes no register. It returns zero read data, and bus_err is high in the one cycle after the request.
- R6: Read data and bus_err appear in the cycle after the request. A privileged read of an unmapped offset returns zero without an error.
- R7: With enable 0, chk_bypass is 1, chk_fault and chk_background are 0 and chk_region is 0, whatever the fallback bit holds.
- R8: With enable 1 and fault-handler protection 0, an access in fault-handler context bypasses protection. With fault-handler protection 1, the same access is checked normally.
- R9: When enabled regions match (hit and enable both 1), the highest-numbered one is reported in chk_region. No fault is raised, and the fallback flag stays 0 even if the fallback map is on.
- R10: With protection active, no enabled match and the fallback bit 0, chk_fault is 1.
- R11: With protection active, no enabled match and the fallback bit 1, a privileged access sets chk_background and does not fault, while an unprivileged access faults.
- R12: cfg_unpredictable is 1 exactly when fault-handler protection is 1 and enable is 0. No fault is raised in that state.
- R13: The access check is combinational: outputs follow the check inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Request comes from privileged software |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Refused-request pulse, one cycle after the request |
| chk_hit | input | 8 | Address match per region |
| chk_en | input | 8 | Enable per region |
| chk_priv | input | 1 | Access is privileged |
| chk_fault_ctx | input | 1 | Access is made from a fault handler |
| chk_region | output | 3 | Index of the governing region |
| chk_background | output | 1 | Fallback map governs the access |
| chk_bypass | output | 1 | Protection is off for this access |
| chk_fault | output | 1 | Access faults |
| cfg_unpredictable | output | 1 | Control holds the undefined setting |

## Verification
On every cycle the assertions check the consistency of the verdict. A fault never coexists with bypass or the fallback flag. The fallback flag only appears for privileged accesses with no enabled match. A reported region really matched, and none with a higher number also did. The undefined setting never faults. A refused request is followed by an error pulse with zero data, and a control write lands on the next edge. The encoding of each register, the masking of out-of-range selectors, the effect of the valid flag on base-address writes, and the full verdict for each context only show up in the bench's directed scenarios, which compare exact values.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;

    localparam int NREG      = 8;
    localparam int IDX_W     = $clog2(NREG);
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;

    localparam logic [ADDR_W-1:0] OFS_CTL  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_SEL  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_BASE = 4'h8;
    localparam int                BASE_VALID_BIT = 4;

    typedef struct packed {
        logic fallback;   // bit 2
        logic hf_guard;   // bit 1
        logic enable;     // bit 0
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef struct packed {
        logic [IDX_W-1:0] region;
        logic             background;
        logic             bypass;
        logic             fault;
    } verdict_t;

    function automatic logic [DATA_W-1:0] widen_ctl(input ctl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_W-1:0] = c;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] widen_idx(input logic [IDX_W-1:0] v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[IDX_W-1:0] = v;
        return w;
    endfunction

endpackage

// File: rtl/mpu_guard_regs.sv
module mpu_guard_regs
    import mpu_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_priv,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output ctl_t              ctl_o,
    output logic [IDX_W-1:0]  sel_o
);

    ctl_t             ctl_q;
    logic [IDX_W-1:0] sel_q;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        unique case (bus_addr)
            OFS_CTL: rd_mux = widen_ctl(ctl_q);
            OFS_SEL: rd_mux = widen_idx(sel_q);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            sel_q     <= '0;
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
            if (bus_valid) begin
                if (!bus_priv) begin
                    bus_err <= 1'b1;
                end else if (bus_write) begin
                    if (bus_addr == OFS_CTL)
                        ctl_q <= ctl_t'(bus_wdata[CTL_W-1:0]);
                    else if (bus_addr == OFS_SEL)
                        sel_q <= bus_wdata[IDX_W-1:0];
                    else if (bus_addr == OFS_BASE && bus_wdata[BASE_VALID_BIT])
                        sel_q <= bus_wdata[IDX_W-1:0];
                end else begin
                    bus_rdata <= rd_mux;
                end
            end
        end
    end

    assign ctl_o = ctl_q;
    assign sel_o = sel_q;

endmodule

// File: rtl/mpu_region_pick.sv
module mpu_region_pick
    import mpu_guard_pkg::*;
#(
    parameter int N   = NREG,
    parameter int IW  = $clog2(N)
) (
    input  logic [N-1:0]  match,
    output logic          any,
    output logic [IW-1:0] winner
);

    logic [N-1:0] above;   // some higher-numbered region matches
    logic [N-1:0] win;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            if (g == N - 1) begin : g_top
                assign above[g] = 1'b0;
            end else begin : g_mid
                assign above[g] = above[g+1] | match[g+1];
            end
            assign win[g] = match[g] & ~above[g];
        end
    endgenerate

    always_comb begin
        winner = '0;
        for (int i = 0; i < N; i++) begin
            if (win[i]) winner = IW'(i);
        end
    end

    assign any = |match;

endmodule

// File: rtl/mpu_access_judge.sv
module mpu_access_judge
    import mpu_guard_pkg::*;
(
    input  ctl_t            ctl,
    input  logic [NREG-1:0] hit,
    input  logic [NREG-1:0] en,
    input  logic            priv,
    input  logic            fault_ctx,
    output verdict_t        verdict,
    output logic            unpredictable
);

    logic             active;
    logic             any;
    logic [IDX_W-1:0] winner;

    mpu_region_pick #(.N(NREG), .IW(IDX_W)) u_pick (
        .match  (hit & en),
        .any    (any),
        .winner (winner)
    );

    assign active        = ctl.enable & ~(fault_ctx & ~ctl.hf_guard);
    assign unpredictable = ctl.hf_guard & ~ctl.enable;

    always_comb begin
        verdict = '0;
        if (!active) begin
            verdict.bypass = 1'b1;
        end else if (any) begin
            verdict.region = winner;
        end else if (ctl.fallback && priv) begin
            verdict.background = 1'b1;
        end else begin
            verdict.fault = 1'b1;
        end
    end

endmodule

// File: rtl/mpu_guard_top.sv
module mpu_guard_top
    import mpu_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_priv,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic [NREG-1:0]   chk_hit,
    input  logic [NREG-1:0]   chk_en,
    input  logic              chk_priv,
    input  logic              chk_fault_ctx,
    output logic [IDX_W-1:0]  chk_region,
    output logic              chk_background,
    output logic              chk_bypass,
    output logic              chk_fault,
    output logic              cfg_unpredictable
);

    ctl_t             ctl_q;
    logic [IDX_W-1:0] sel_q;
    verdict_t         verdict;

    mpu_guard_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_priv  (bus_priv),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .ctl_o     (ctl_q),
        .sel_o     (sel_q)
    );

    mpu_access_judge u_judge (
        .ctl           (ctl_q),
        .hit           (chk_hit),
        .en            (chk_en),
        .priv          (chk_priv),
        .fault_ctx     (chk_fault_ctx),
        .verdict       (verdict),
        .unpredictable (cfg_unpredictable)
    );

    assign chk_region     = verdict.region;
    assign chk_background = verdict.background;
    assign chk_bypass     = verdict.bypass;
    assign chk_fault      = verdict.fault;

endmodule

// File: rtl/mpu_guard_chk.sv
module mpu_guard_chk
    import mpu_guard_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              bus_priv,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic [CTL_W-1:0]  ctl_bits,
    input logic [NREG-1:0]   chk_hit,
    input logic [NREG-1:0]   chk_en,
    input logic              chk_priv,
    input logic [IDX_W-1:0]  chk_region,
    input logic              chk_background,
    input logic              chk_bypass,
    input logic              chk_fault,
    input logic              cfg_unpredictable
);

    logic [NREG-1:0] match;
    assign match = chk_hit & chk_en;

    // R5: error pulse only after a refused request, with zero data
    p_err_after_unpriv_r5: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> ($past(bus_valid) && !$past(bus_priv) && bus_rdata == '0));

    // R2: privileged control write lands on the next edge
    p_ctl_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_valid && bus_priv && bus_write && bus_addr == OFS_CTL))
        |-> ctl_bits == $past(bus_wdata[CTL_W-1:0]));

    // R10: a fault is never combined with bypass or fallback
    p_fault_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        chk_fault |-> (!chk_bypass && !chk_background));

    // R11: fallback only for privileged accesses without an enabled match
    p_fallback_priv_r11: assert property (@(posedge clk) disable iff (rst)
        chk_background |-> (chk_priv && match == '0 && !chk_bypass));

    // R9: reported region matched and nothing above it matched
    p_winner_highest_r9: assert property (@(posedge clk) disable iff (rst)
        (!chk_bypass && match != '0) |->
            (match[chk_region] && (match >> chk_region) == 1 && !chk_fault));

    // R7: bypass carries no other verdict
    p_bypass_clean_r7: assert property (@(posedge clk) disable iff (rst)
        chk_bypass |-> (!chk_fault && !chk_background && chk_region == '0));

    // R12: the undefined setting never faults
    p_unpredictable_safe_r12: assert property (@(posedge clk) disable iff (rst)
        cfg_unpredictable |-> (chk_bypass && !chk_fault));

endmodule

bind mpu_guard_top mpu_guard_chk u_chk (
    .clk               (clk),
    .rst               (rst),
    .bus_valid         (bus_valid),
    .bus_write         (bus_write),
    .bus_priv          (bus_priv),
    .bus_addr          (bus_addr),
    .bus_wdata         (bus_wdata),
    .bus_rdata         (bus_rdata),
    .bus_err           (bus_err),
    .ctl_bits          (ctl_q),
    .chk_hit           (chk_hit),
    .chk_en            (chk_en),
    .chk_priv          (chk_priv),
    .chk_region        (chk_region),
    .chk_background    (chk_background),
    .chk_bypass        (chk_bypass),
    .chk_fault         (chk_fault),
    .cfg_unpredictable (cfg_unpredictable)
);

// File: tb/mpu_guard_top_bench.sv
module mpu_guard_top_bench;
    import mpu_guard_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic              bus_priv  = 1'b0;
    logic [ADDR_W-1:0] bus_addr  = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_err;
    logic [NREG-1:0]   chk_hit = '0;
    logic [NREG-1:0]   chk_en  = '0;
    logic              chk_priv = 1'b0;
    logic              chk_fault_ctx = 1'b0;
    logic [IDX_W-1:0]  chk_region;
    logic              chk_background;
    logic              chk_bypass;
    logic              chk_fault;
    logic              cfg_unpredictable;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mpu_guard_top u_mpu_guard_top (.*);

    task automatic expect_eq(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_do(input logic wr, input logic priv, input logic [ADDR_W-1:0] a,
                          input logic [31:0] d, output logic [31:0] rd, output logic err);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_priv = priv; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        rd  = bus_rdata;
        err = bus_err;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        logic [31:0] rd; logic err;
        bus_do(1'b1, 1'b1, a, d, rd, err);
    endtask

    task automatic rd_check(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic err;
        bus_do(1'b0, 1'b1, a, '0, rd, err);
        expect_eq(req, "read data", rd, exp);
        expect_eq(req, "no error", {31'b0, err}, 32'd0);
    endtask

    // expected verdict packed as {region, background, bypass, fault}
    task automatic access(input string req, input logic [7:0] hit, input logic [7:0] en,
                          input logic priv, input logic ctx, input logic [5:0] exp);
        chk_hit = hit; chk_en = en; chk_priv = priv; chk_fault_ctx = ctx;
        #1;
        expect_eq(req, "verdict", {26'b0, chk_region, chk_background, chk_bypass, chk_fault},
                  {26'b0, exp});
    endtask

    task automatic t_reset;
        rd_check("R1", OFS_CTL, 32'd0);
        rd_check("R1", OFS_SEL, 32'd0);
    endtask

    task automatic t_registers;
        wr(OFS_CTL, 32'hFFFF_FFFD);
        rd_check("R2", OFS_CTL, 32'd5);
        wr(OFS_SEL, 32'd13);
        rd_check("R3", OFS_SEL, 32'd5);
        wr(OFS_BASE, 32'h0000_0012);
        rd_check("R4", OFS_SEL, 32'd2);
        wr(OFS_BASE, 32'h0000_0006);
        rd_check("R4", OFS_SEL, 32'd2);
        rd_check("R4", OFS_BASE, 32'd0);
        rd_check("R6", 4'hC, 32'd0);
    endtask

    task automatic t_unpriv;
        logic [31:0] rd; logic err;
        bus_do(1'b1, 1'b0, OFS_CTL, 32'd0, rd, err);
        expect_eq("R5", "write error", {31'b0, err}, 32'd1);
        bus_do(1'b0, 1'b0, OFS_CTL, 32'd0, rd, err);
        expect_eq("R5", "read data", rd, 32'd0);
        expect_eq("R5", "read error", {31'b0, err}, 32'd1);
        @(posedge clk); #1;
        expect_eq("R5", "error one cycle", {31'b0, bus_err}, 32'd0);
        bus_do(1'b1, 1'b0, OFS_BASE, 32'h17, rd, err);
        rd_check("R5", OFS_CTL, 32'd5);
        rd_check("R5", OFS_SEL, 32'd2);
    endtask

    task automatic t_disabled;
        wr(OFS_CTL, 32'd4);
        access("R7", 8'h00, 8'h00, 1'b0, 1'b0, 6'b000_010);
        access("R7", 8'h80, 8'h80, 1'b1, 1'b0, 6'b000_010);
        expect_eq("R12", "unpredictable off", {31'b0, cfg_unpredictable}, 32'd0);
        wr(OFS_CTL, 32'd2);
        access("R12", 8'h00, 8'h00, 1'b0, 1'b0, 6'b000_010);
        expect_eq("R12", "unpredictable on", {31'b0, cfg_unpredictable}, 32'd1);
    endtask

    task automatic t_enabled;
        wr(OFS_CTL, 32'd1);
        access("R9", 8'h25, 8'hFF, 1'b0, 1'b0, {3'd5, 3'b000});
        access("R9", 8'h25, 8'h05, 1'b0, 1'b0, {3'd2, 3'b000});
        access("R13", 8'h81, 8'hFF, 1'b1, 1'b0, {3'd7, 3'b000});
        access("R10", 8'hF0, 8'h0F, 1'b1, 1'b0, 6'b000_001);
        access("R8", 8'h00, 8'h00, 1'b0, 1'b1, 6'b000_010);
        wr(OFS_CTL, 32'd5);
        access("R11", 8'h00, 8'hFF, 1'b1, 1'b0, 6'b000_100);
        access("R11", 8'h00, 8'hFF, 1'b0, 1'b0, 6'b000_001);
        access("R9", 8'h01, 8'h01, 1'b1, 1'b0, {3'd0, 3'b000});
        wr(OFS_CTL, 32'd3);
        access("R8", 8'h00, 8'h00, 1'b1, 1'b1, 6'b000_001);
        access("R8", 8'h08, 8'h08, 1'b0, 1'b1, {3'd3, 3'b000});
        expect_eq("R12", "unpredictable off", {31'b0, cfg_unpredictable}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_registers();
        t_unpriv();
        t_disabled();
        t_enabled();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule